// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block accepts one load or store request on behalf of a group of 16 lanes and turns it into a short list of aligned memory transactions. Each lane brings an active flag and a byte address. All lanes in a request share one access width: 8, 16, 32 or 64 bits. The block bundles every active lane whose address lands in the same aligned segment into a single transaction, whatever the lane-to-address mapping. Each transaction is then trimmed to the smallest aligned size, 32, 64 or 128 bytes, that still covers the bytes its lanes asked for. The consumer receives one transaction per cycle under a ready/valid handshake, and a one-cycle `done` pulse marks the end of the request.

The controller is a five-state machine. ST_IDLE raises `req_ready` and moves to ST_CHECK when a request is accepted. In ST_CHECK, a misaligned active lane sends it to ST_FAULT, an empty active mask sends it to ST_FIN, and any other request sends it to ST_EMIT. ST_EMIT presents the group led by the lowest-numbered pending lane. On acceptance it stays in ST_EMIT while lanes remain and goes to ST_FIN once none remain. ST_FIN pulses `done` and ST_FAULT pulses `err`, and both return to ST_IDLE.

Top module: `hw_coalescer`

## Requirements
- R1: The segment size follows `req_width` (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit words): 32 bytes for code 0, 64 bytes for code 1, and 128 bytes for codes 2 and 3.
- R2: All pending active lanes whose addresses share one aligned segment are served by a single transaction, for any lane ordering and when several lanes use an identical address.
- R3: Transactions are emitted in order of their lowest-numbered pending lane. `tx_lanes` is the set of lanes claimed by that lane's segment.
- R4: `tx_size` (0 = 32 B, 1 = 64 B, 2 = 128 B) is the smallest size that holds every claimed word. A 128-byte group whose words all sit in one 64-byte half shrinks to 64 bytes. A 64-byte group whose words all sit in one 32-byte half shrinks to 32 bytes.
- R5: `tx_base` is the leading lane's address with its low bits cleared to the alignment of the final `tx_size`.
- R6: When every active lane lies in a distinct segment, one transaction per active lane is issued, up to 16 for a request.
- R7: Inactive lanes have no effect, even when their addresses are misaligned. A request with no active lanes pulses `done` without any transaction.
- R8: An active lane whose address is not a multiple of the word size causes a one-cycle `err` pulse. The request is then dropped, with no transaction and no `done`.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_base`, `tx_size` and `tx_lanes` hold steady. `req_ready` is high only in the idle state, and never together with `tx_valid` or `done`.
- R10: `done` pulses for exactly one cycle, in the cycle after the final transaction is accepted.
- R11: After reset, `req_ready` is 1 and `tx_valid`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_active | input | LANES | Per-lane active flags |
| req_addr | input | LANES*AW | Lane byte addresses; lane i at bits [i*AW +: AW] |
| req_width | input | 2 | Access width code |
| tx_valid | output | 1 | Transaction present |
| tx_ready | input | 1 | Consumer accepts transaction |
| tx_base | output | AW | Aligned transaction base address |
| tx_size | output | 2 | Transaction size code |
| tx_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request dropped on misalignment (one cycle) |

## Verification
Two actions can coincide in one cycle: the consumer accepting the last pending group, and the controller deciding whether to stay in ST_EMIT or move to ST_FIN. The bench provokes this by stalling `tx_ready` on a regular pattern, so that some final acceptances follow a stall and others come straight away. In each case it checks that `done` appears exactly one cycle after the last accepted transaction, with `req_ready` still low. It also checks that a stalled transaction keeps its fields unchanged until it is taken.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
    typedef enum logic [1:0] {
        W8  = 2'd0,
        W16 = 2'd1,
        W32 = 2'd2,
        W64 = 2'd3
    } width_e;

    typedef enum logic [1:0] {
        SZ32  = 2'd0,
        SZ64  = 2'd1,
        SZ128 = 2'd2
    } tsize_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_EMIT,
        ST_FIN,
        ST_FAULT
    } state_e;

    function automatic logic [2:0] seg_shift(input width_e w);
        unique case (w)
            W8:      seg_shift = 3'd5;
            W16:     seg_shift = 3'd6;
            default: seg_shift = 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/hwc_align_chk.sv
module hwc_align_chk
    import hwc_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [LANES-1:0]   active,
    input  logic [LANES*3-1:0] lo3,
    input  width_e             width,
    output logic               any_bad
);
    logic [LANES-1:0] lane_bad;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [2:0] lo;
        assign lo = lo3[g*3 +: 3];
        always_comb begin
            unique case (width)
                W8:      lane_bad[g] = 1'b0;
                W16:     lane_bad[g] = lo[0];
                W32:     lane_bad[g] = |lo[1:0];
                default: lane_bad[g] = |lo[2:0];
            endcase
        end
    end

    assign any_bad = |(active & lane_bad);
endmodule

// File: rtl/hwc_seg_pick.sv
module hwc_seg_pick
    import hwc_pkg::*;
#(
    parameter int LANES = 16,
    parameter int AW    = 32
) (
    input  logic [LANES-1:0]    pending,
    input  logic [LANES*AW-1:0] addr,
    input  width_e              width,
    output logic [AW-1:0]       lead_addr,
    output logic [LANES-1:0]    claim
);
    localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [IW-1:0] lead;
    logic [2:0]    sh;

    // lowest-numbered pending lane leads the group
    always_comb begin
        lead = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) lead = IW'(i);
        end
    end

    assign sh        = seg_shift(width);
    assign lead_addr = addr[lead*AW +: AW];

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        logic [AW-1:0] a;
        assign a        = addr[g*AW +: AW];
        assign claim[g] = pending[g] && ((a >> sh) == (lead_addr >> sh));
    end
endmodule

// File: rtl/hwc_shrink.sv
module hwc_shrink
    import hwc_pkg::*;
#(
    parameter int LANES = 16,
    parameter int AW    = 32
) (
    input  logic [LANES-1:0] claim,
    input  logic [LANES-1:0] b5,
    input  logic [LANES-1:0] b6,
    input  width_e           width,
    input  logic [AW-1:0]    lead_addr,
    output logic [AW-1:0]    base,
    output tsize_e           size
);
    logic same5;
    logic same6;

    // a half is uniform when no claimed lane or every claimed lane has the bit set
    assign same5 = ((claim & b5) == '0) || ((claim & b5) == claim);
    assign same6 = ((claim & b6) == '0) || ((claim & b6) == claim);

    always_comb begin
        unique case (width)
            W8:      size = SZ32;
            W16:     size = same5 ? SZ32 : SZ64;
            default: size = same6 ? (same5 ? SZ32 : SZ64) : SZ128;
        endcase
    end

    always_comb begin
        unique case (size)
            SZ32:    base = {lead_addr[AW-1:5], 5'b0};
            SZ64:    base = {lead_addr[AW-1:6], 6'b0};
            default: base = {lead_addr[AW-1:7], 7'b0};
        endcase
    end
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
    import hwc_pkg::*;
#(
    parameter int LANES = 16,
    parameter int AW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [1:0]          req_width,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic [AW-1:0]       tx_base,
    output logic [1:0]          tx_size,
    output logic [LANES-1:0]    tx_lanes,
    output logic                done,
    output logic                err
);
    state_e              state_q, state_d;
    logic [LANES*AW-1:0] addr_q;
    width_e              width_q;
    logic [LANES-1:0]    pending_q;

    logic [LANES-1:0]    claim;
    logic [AW-1:0]       lead_addr;
    logic [AW-1:0]       grp_base;
    tsize_e              grp_size;
    logic                any_bad;
    logic [LANES-1:0]    b5, b6;
    logic [LANES*3-1:0]  lo3;
    logic [LANES-1:0]    left_after;

    for (genvar g = 0; g < LANES; g++) begin : g_bits
        assign b5[g]          = addr_q[g*AW + 5];
        assign b6[g]          = addr_q[g*AW + 6];
        assign lo3[g*3 +: 3]  = addr_q[g*AW +: 3];
    end

    hwc_align_chk #(.LANES(LANES)) u_align (
        .active  (pending_q),
        .lo3     (lo3),
        .width   (width_q),
        .any_bad (any_bad)
    );

    hwc_seg_pick #(.LANES(LANES), .AW(AW)) u_pick (
        .pending   (pending_q),
        .addr      (addr_q),
        .width     (width_q),
        .lead_addr (lead_addr),
        .claim     (claim)
    );

    hwc_shrink #(.LANES(LANES), .AW(AW)) u_shrink (
        .claim     (claim),
        .b5        (b5),
        .b6        (b6),
        .width     (width_q),
        .lead_addr (lead_addr),
        .base      (grp_base),
        .size      (grp_size)
    );

    assign left_after = pending_q & ~claim;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (any_bad)              state_d = ST_FAULT;
                else if (pending_q == '0) state_d = ST_FIN;
                else                      state_d = ST_EMIT;
            end
            ST_EMIT:  if (tx_ready && left_after == '0) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request capture and pending mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            width_q   <= W8;
            pending_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q    <= req_addr;
            width_q   <= width_e'(req_width);
            pending_q <= req_active;
        end else if (state_q == ST_EMIT && tx_ready) begin
            pending_q <= left_after;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        tx_valid  = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        tx_base   = '0;
        tx_size   = 2'd0;
        tx_lanes  = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_CHECK: ;
            ST_EMIT: begin
                tx_valid = 1'b1;
                tx_base  = grp_base;
                tx_size  = grp_size;
                tx_lanes = claim;
            end
            ST_FIN:   done = 1'b1;
            ST_FAULT: err  = 1'b1;
            default:  ;
        endcase
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_base) && $stable(tx_size) && $stable(tx_lanes)));

    p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (tx_valid || done)));

    p_lanes_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_lanes != '0 && (tx_lanes & ~pending_q) == '0));

    p_base_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_base[4:0] == 5'd0 && (tx_size == 2'd0 || tx_base[5] == 1'b0)
                      && (tx_size != 2'd2 || tx_base[6] == 1'b0)));

    p_done_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(tx_valid && tx_ready) || $past(state_q == ST_CHECK)));

    p_err_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!tx_valid && !done && !req_ready));
endmodule

// File: tb/hw_coalescer_bench.sv
module hw_coalescer_bench;
    localparam int LANES = 16;
    localparam int AW    = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [LANES-1:0]    req_active = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [1:0]          req_width = 2'd0;
    logic                tx_valid;
    logic                tx_ready = 1'b0;
    logic [AW-1:0]       tx_base;
    logic [1:0]          tx_size;
    logic [LANES-1:0]    tx_lanes;
    logic                done;
    logic                err;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0]    lane_addr [LANES];
    logic [LANES-1:0] lane_act;
    logic [1:0]       lane_w;

    logic [AW-1:0]    exp_base  [LANES];
    logic [1:0]       exp_size  [LANES];
    logic [LANES-1:0] exp_lanes [LANES];
    int               exp_n;

    always #10 clk = ~clk;

    hw_coalescer #(.LANES(LANES), .AW(AW)) u_hw_coalescer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr), .req_width(req_width),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_base(tx_base), .tx_size(tx_size), .tx_lanes(tx_lanes),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // reference: greedy grouping by lowest pending lane, then halve while possible
    task automatic build_model();
        logic [LANES-1:0] pend = lane_act;
        exp_n = 0;
        while (pend != '0) begin
            int lead = 0;
            int sh;
            int sz;
            logic [LANES-1:0] cl = '0;
            bit s5 = 1'b1;
            bit s6 = 1'b1;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
            sh = (lane_w == 2'd0) ? 5 : (lane_w == 2'd1) ? 6 : 7;
            for (int j = 0; j < LANES; j++)
                if (pend[j] && ((lane_addr[j] >> sh) == (lane_addr[lead] >> sh))) cl[j] = 1'b1;
            for (int j = 0; j < LANES; j++) if (cl[j]) begin
                if (lane_addr[j][5] != lane_addr[lead][5]) s5 = 1'b0;
                if (lane_addr[j][6] != lane_addr[lead][6]) s6 = 1'b0;
            end
            sz = 1 << sh;
            if (sz == 128 && s6) sz = 64;
            if (sz == 64 && s5) sz = 32;
            exp_base[exp_n]  = lane_addr[lead] & ~AW'(sz - 1);
            exp_size[exp_n]  = (sz == 32) ? 2'd0 : (sz == 64) ? 2'd1 : 2'd2;
            exp_lanes[exp_n] = cl;
            exp_n++;
            pend &= ~cl;
        end
    endtask

    task automatic run_req(input string name, input bit stall, input bit exp_err);
        int got = 0;
        int cyc = 0;
        int last_acc = -10;
        bit fin = 1'b0;
        bit saw_err = 1'b0;
        bit saw_done = 1'b0;
        bit held = 1'b0;
        logic [AW-1:0] hb;
        logic [1:0] hs;
        logic [LANES-1:0] hl;
        build_model();
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", {name, " idle ready"}, req_ready, 1);
        req_valid  = 1'b1;
        req_active = lane_act;
        req_width  = lane_w;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = lane_addr[i];
        @(negedge clk);
        req_valid  = 1'b0;
        req_active = '0;
        while (!fin && cyc < 200) begin
            if (err) begin
                saw_err = 1'b1;
                fin = 1'b1;
            end else if (done) begin
                saw_done = 1'b1;
                fin = 1'b1;
                chk(req_ready == 1'b0, "R9", {name, " no ready during done"}, req_ready, 0);
                if (exp_n > 0)
                    chk(cyc == last_acc + 1, "R10", {name, " done timing"}, cyc - last_acc, 1);
            end else begin
                if (held)
                    chk(tx_valid && tx_base == hb && tx_size == hs && tx_lanes == hl,
                        "R9", {name, " stalled hold"}, tx_base, hb);
                held = 1'b0;
                if (tx_valid) begin
                    bit rdy = !(stall && (cyc % 3 == 1));
                    if (!rdy) begin
                        hb = tx_base; hs = tx_size; hl = tx_lanes; held = 1'b1;
                    end else begin
                        if (got < exp_n) begin
                            chk(tx_lanes == exp_lanes[got], "R3", {name, " lanes"}, tx_lanes, exp_lanes[got]);
                            chk(tx_size == exp_size[got], "R4", {name, " size"}, tx_size, exp_size[got]);
                            chk(tx_base == exp_base[got], "R5", {name, " base"}, tx_base, exp_base[got]);
                        end
                        got++;
                        last_acc = cyc;
                    end
                    tx_ready = rdy;
                end else begin
                    tx_ready = 1'b0;
                end
            end
            @(negedge clk);
            cyc++;
        end
        tx_ready = 1'b0;
        chk(saw_err == exp_err, "R8", {name, " err flag"}, saw_err, exp_err);
        chk(saw_done == !exp_err, "R10", {name, " done seen"}, saw_done, !exp_err);
        chk(got == (exp_err ? 0 : exp_n), "R2", {name, " transaction count"}, got, exp_err ? 0 : exp_n);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1 && !tx_valid && !done && !err, "R11", "reset outputs",
            {req_ready, tx_valid, done, err}, 4'b1000);
    endtask

    task automatic t_one_segment();
        lane_w = 2'd2; lane_act = '1;
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h1000 + 4 * i;
        run_req("R2 one segment", 1'b0, 1'b0);
        chk(exp_n == 1 && exp_size[0] == 2'd1, "R4", "one segment model 64B", exp_size[0], 1);
    endtask

    task automatic t_reversed();
        lane_w = 2'd2; lane_act = '1;
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h2080 + 4 * (LANES - 1 - i);
        run_req("R2 reversed", 1'b1, 1'b0);
    endtask

    task automatic t_dup();
        lane_w = 2'd2; lane_act = '1;
        for (int i = 0; i < LANES; i++) lane_addr[i] = (i % 2 == 0) ? 32'h3004 : 32'h3010;
        run_req("R2 duplicates", 1'b0, 1'b0);
    endtask

    task automatic t_scatter();
        lane_w = 2'd2; lane_act = '1;
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h10000 + 256 * (LANES - 1 - i) + 4 * i;
        run_req("R6 scattered", 1'b1, 1'b0);
        chk(exp_n == LANES, "R6", "scatter gives one per lane", exp_n, LANES);
    endtask

    task automatic t_partial();
        lane_w = 2'd2; lane_act = 16'h5555;
        for (int i = 0; i < LANES; i++) lane_addr[i] = (i % 2 == 0) ? 32'h600 + 4 * i : 32'h7;
        run_req("R7 partial", 1'b0, 1'b0);
    endtask

    task automatic t_empty();
        lane_w = 2'd3; lane_act = '0;
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h5;
        run_req("R7 empty", 1'b0, 1'b0);
    endtask

    task automatic t_misaligned();
        lane_w = 2'd1; lane_act = '1;
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h9000 + 2 * i;
        lane_addr[3] = 32'h9007;
        run_req("R8 misaligned", 1'b0, 1'b1);
        @(negedge clk);
        chk(!done && req_ready, "R8", "no done after err", done, 0);
    endtask

    task automatic t_widths();
        lane_act = '1;
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h9000 + 2 * i + ((i >= 8) ? 16 : 0);
        lane_w = 2'd1;
        run_req("R1 16-bit", 1'b0, 1'b0);
        chk(exp_n == 1, "R1", "16-bit single segment", exp_n, 1);
        lane_w = 2'd0;
        run_req("R1 8-bit", 1'b1, 1'b0);
        chk(exp_n == 2, "R1", "8-bit splits", exp_n, 2);
        lane_w = 2'd3;
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h8000 + 8 * i;
        run_req("R1 64-bit", 1'b0, 1'b0);
        chk(exp_size[0] == 2'd2, "R1", "64-bit full 128B", exp_size[0], 2);
    endtask

    task automatic t_shrink_upper();
        lane_w = 2'd2; lane_act = '1;
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h40E0 + 4 * (i % 8);
        run_req("R4 upper quarter", 1'b1, 1'b0);
        chk(exp_base[0] == 32'h40E0 && exp_size[0] == 2'd0, "R5", "upper quarter model",
            exp_base[0], 32'h40E0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_one_segment();
        t_reversed();
        t_dup();
        t_scatter();
        t_partial();
        t_empty();
        t_misaligned();
        t_widths();
        t_shrink_upper();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule